// File: doc/BRIEF.md
# DMA Snoop Decompression Trigger

This block sits beside a host CPU's DMA controller and the cartridge ROM path. It watches CPU writes to the DMA channel parameter registers without blocking them, and keeps its own shadow copy of each channel's 24-bit source address and 16-bit byte count. It also holds two enable bytes. One byte is a channel-enable mask, and the other is a decompression-arm mask. A channel is eligible when its bit is set in both bytes.

When the CPU reads from banks C0-FF, the block compares the read address with the shadow address of every eligible channel. If none match, the read is served from ROM data. If one matches, the block opens a decompression stream on an external decompressor, but only when no stream is already open. It then returns the next decompressed byte in place of ROM data and counts that channel's shadow size down by one.

A DMA transfer from a fixed source address therefore pulls exactly the snooped number of bytes out of the decompressor. When the count reaches zero, the stream closes and the channel disarms itself.

Top module: `dma_unpack_tap`

## Requirements
- R1: A write with address bit 22 clear and low 16 address bits in 4300-437F is snooped for channel bits 6:4. Offsets 2, 3 and 4 (bits 3:0) load the low, middle and high byte of that channel's shadow source address. Writes with bit 22 set, or outside that window, change no shadow.
- R2: Offsets 5 and 6 of a snooped channel load the low and high byte of its 16-bit shadow size. Each byte write leaves the other byte unchanged.
- R3: A write with bit 22 clear to low address 4800 loads the channel-enable byte `chan_on`. A write to 4801 loads the arm byte `unpk_on`. Any other address, and any write with bit 22 set, leaves both bytes unchanged.
- R4: A read is accepted when `rd_req` is high and no streamed read is pending. It falls through to ROM when its address bits 23:22 are not 11, or when no channel with both enable bits set has a shadow address equal to it. Then `rd_done` pulses in the next cycle with `rd_data` equal to the `rom_data` sampled at acceptance.
- R5: When several eligible channels match, the lowest-numbered one is used.
- R6: An accepted matching read while `stream_open` is low pulses `unp_init` in the same cycle, with `unp_addr` equal to the read address, and `stream_open` is high from the next cycle. While `stream_open` is high, `unp_init` stays low.
- R7: After an accepted matching read, `unp_take` is high from the next cycle until the cycle in which `unp_valid` is high. `rd_done` then pulses one cycle later, with `rd_data` equal to the `unp_byte` taken.
- R8: Each taken byte decrements the selected channel's shadow size. When the count reaches zero, `stream_open` falls and that channel's `unpk_on` bit clears in the same cycle that `rd_done` rises. A CPU write to the same bit in that cycle loses to the clear. `unpk_on` bits never rise except through a write.
- R9: A shadow size of 0 wraps to FFFF on the first taken byte and does not end the transfer.
- R10: Reset clears every shadow address and size, both enable bytes, `stream_open`, `rd_done` and `unp_take`.
- R11: A `rd_req` that arrives while a streamed read is pending is ignored. It produces no `rd_done`, no `unp_init` and no decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 24 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_req | input | 1 | CPU read request pulse |
| rd_addr | input | 24 | CPU read address |
| rom_data | input | 8 | ROM data for the read address |
| rd_done | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data returned to the CPU |
| unp_init | output | 1 | Open a decompression stream |
| unp_addr | output | 24 | Stream start address |
| unp_take | output | 1 | Ready for one decompressed byte |
| unp_valid | input | 1 | Decompressed byte available |
| unp_byte | input | 8 | Decompressed byte |
| chan_on | output | 8 | Channel-enable byte |
| unpk_on | output | 8 | Decompression-arm byte |
| stream_open | output | 1 | A decompression stream is open |

## Verification
A corrupted shadow address shows up on the next C0-FF read at that address, which comes back as ROM data instead of a stream byte, or the other way round. A wrong shadow size shows up as an `unpk_on` bit that clears one pop too early or too late. A stuck `stream_open` flag shows up at the next transfer start as a missing or repeated `unp_init`. A reference model tracks the shadows, the enables and the pending read, and compares every output on every clock. Each of these faults is therefore reported in the very cycle the ports first differ.

// File: rtl/dma_unpack_tap.sv
module dma_unpack_tap #(
  parameter int NCH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [23:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_req,
  input  logic [23:0] rd_addr,
  input  logic [7:0]  rom_data,
  output logic        rd_done,
  output logic [7:0]  rd_data,
  output logic        unp_init,
  output logic [23:0] unp_addr,
  output logic        unp_take,
  input  logic        unp_valid,
  input  logic [7:0]  unp_byte,
  output logic [7:0]  chan_on,
  output logic [7:0]  unpk_on,
  output logic        stream_open
);
  localparam int CW = $clog2(NCH);
  localparam int AW = 24;
  localparam int SW = 16;

  logic [AW-1:0] sh_addr [NCH];
  logic [SW-1:0] sh_size [NCH];
  logic          busy, hit, accept, pop, finish;
  logic [CW-1:0] cur_ch, hit_ch, snp_ch;
  logic [SW-1:0] size_nxt;
  logic [NCH-1:0] elig, fin_mask;

  wire io_sel = wr_en & ~wr_addr[22];
  wire snp_we = io_sel && wr_addr[15:8] == 8'h43 && 32'(wr_addr[7:4]) < NCH;
  wire on_we  = io_sel && wr_addr[15:0] == 16'h4800;
  wire arm_we = io_sel && wr_addr[15:0] == 16'h4801;
  assign snp_ch = wr_addr[4 +: CW];

  assign elig = chan_on[NCH-1:0] & unpk_on[NCH-1:0];

  always_comb begin
    hit    = 1'b0;
    hit_ch = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (rd_addr[23:22] == 2'b11 && elig[c] && sh_addr[c] == rd_addr) begin
        hit    = 1'b1;
        hit_ch = CW'(c);
      end
    end
  end

  assign accept   = rd_req & ~busy;
  assign unp_init = accept & hit & ~stream_open;
  assign unp_addr = rd_addr;
  assign unp_take = busy;
  assign pop      = busy & unp_valid;
  assign size_nxt = sh_size[cur_ch] - 1'b1;
  assign finish   = pop && size_nxt == '0;
  assign fin_mask = finish ? (NCH'(1) << cur_ch) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sh_addr[c] <= '0;
        sh_size[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (pop && cur_ch == CW'(c)) sh_size[c] <= size_nxt;
        if (snp_we && snp_ch == CW'(c)) begin
          case (wr_addr[3:0])
            4'h2: sh_addr[c][7:0]   <= wr_data;
            4'h3: sh_addr[c][15:8]  <= wr_data;
            4'h4: sh_addr[c][23:16] <= wr_data;
            4'h5: sh_size[c][7:0]   <= wr_data;
            4'h6: sh_size[c][15:8]  <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_on <= '0;
      unpk_on <= '0;
    end else begin
      if (on_we) chan_on <= wr_data;
      unpk_on <= (arm_we ? wr_data : unpk_on) & ~8'(fin_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cur_ch      <= '0;
      stream_open <= 1'b0;
      rd_done     <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_done <= (accept & ~hit) | pop;
      if (accept && hit) begin
        busy   <= 1'b1;
        cur_ch <= hit_ch;
      end else if (pop) begin
        busy <= 1'b0;
      end
      if (unp_init) stream_open <= 1'b1;
      else if (finish) stream_open <= 1'b0;
      if (pop) rd_data <= unp_byte;
      else if (accept && !hit) rd_data <= rom_data;
    end
  end
endmodule

module dma_unpack_tap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_req,
  input logic       rd_done,
  input logic [7:0] rd_data,
  input logic [7:0] rom_data,
  input logic       unp_init,
  input logic       unp_take,
  input logic       unp_valid,
  input logic [7:0] unp_byte,
  input logic [7:0] unpk_on,
  input logic       stream_open,
  input logic       busy,
  input logic       hit
);
  // R4
  rom_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !busy && !hit) |=> (rd_done && rd_data == $past(rom_data)));
  // R6
  init_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unp_init |=> stream_open);
  // R6
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stream_open |-> !unp_init);
  // R7
  pop_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unp_take && unp_valid) |=> (rd_done && rd_data == $past(unp_byte)));
  // R7
  take_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unp_take |-> !rd_done);
  // R8
  arm_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((unpk_on & ~$past(unpk_on)) == 8'h00));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unp_take && !unp_valid) |=> !rd_done);
endmodule

bind dma_unpack_tap dma_unpack_tap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
  .rd_done(rd_done), .rd_data(rd_data), .rom_data(rom_data),
  .unp_init(unp_init), .unp_take(unp_take), .unp_valid(unp_valid),
  .unp_byte(unp_byte), .unpk_on(unpk_on), .stream_open(stream_open),
  .busy(busy), .hit(hit)
);

// File: tb/dma_unpack_tap_test.sv
module dma_unpack_tap_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_req = 0;
  logic [23:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rom_data = 0;
  logic rd_done, unp_init, unp_take, unp_valid, stream_open;
  logic [7:0] rd_data, unp_byte, chan_on, unpk_on;
  logic [23:0] unp_addr;

  int total = 0, bad = 0;
  int n_done = 0, n_init = 0;
  logic [31:0] cyc = 0;
  bit fast = 1;
  logic [7:0] st_base = 0, st_k = 0;

  dma_unpack_tap uut (.*);

  always #2 clk = ~clk;

  assign unp_valid = fast || (cyc[1:0] == 2'b11);
  assign unp_byte  = st_base ^ st_k;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (unp_init) begin st_base <= unp_addr[7:0]; st_k <= 0; end
    else if (unp_take && unp_valid) st_k <= st_k + 1;
    if (rd_done) n_done++;
    if (unp_init) n_init++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [23:0] m_addr [8];
  int          m_size [8];
  logic [7:0]  m_chon, m_unon, m_data;
  bit          m_open, m_wait, m_done;
  int          m_ch;
  string       m_kind = "R4";

  function automatic int m_find(logic [23:0] a);
    if (a[23:22] != 2'b11) return -1;
    for (int c = 0; c < 8; c++)
      if (m_chon[c] && m_unon[c] && m_addr[c] == a) return c;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin m_addr[c] = 0; m_size[c] = 0; end
      m_chon = 0; m_unon = 0; m_data = 0;
      m_open = 0; m_wait = 0; m_done = 0; m_ch = 0;
    end else begin
      int h, ch;
      bit fin, nd;
      logic [7:0] ndat;
      fin = 0; nd = 0; ndat = m_data;
      if (!m_wait && rd_req) begin
        h = m_find(rd_addr);
        if (h < 0) begin nd = 1; ndat = rom_data; m_kind = "R4"; end
        else begin m_open = 1; m_wait = 1; m_ch = h; m_kind = "R7"; end
      end else if (m_wait && unp_valid) begin
        nd = 1; ndat = unp_byte; m_wait = 0;
        m_size[m_ch] = (m_size[m_ch] + 65535) % 65536;
        fin = (m_size[m_ch] == 0);
      end
      if (wr_en && !wr_addr[22]) begin
        if (wr_addr[15:8] == 8'h43 && !wr_addr[7]) begin
          ch = int'(wr_addr[6:4]);
          case (wr_addr[3:0])
            4'h2: m_addr[ch][7:0]   = wr_data;
            4'h3: m_addr[ch][15:8]  = wr_data;
            4'h4: m_addr[ch][23:16] = wr_data;
            4'h5: m_size[ch] = (m_size[ch] & 32'hFF00) | int'(wr_data);
            4'h6: m_size[ch] = (m_size[ch] & 32'h00FF) | (int'(wr_data) << 8);
            default: ;
          endcase
        end
        if (wr_addr[15:0] == 16'h4800) m_chon = wr_data;
        if (wr_addr[15:0] == 16'h4801) m_unon = wr_data;
      end
      if (fin) begin m_open = 0; m_unon[m_ch] = 1'b0; end
      m_done = nd; m_data = ndat;
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e_init;
    e_init = rd_req && !m_wait && (m_find(rd_addr) >= 0) && !m_open;
    chk("R6 unp_init", unp_init, e_init);
    if (e_init) chk("R6 unp_addr", unp_addr, rd_addr);
    chk("R7 unp_take", unp_take, m_wait);
    chk("R11 rd_done", rd_done, m_done);
    if (m_done) chk({m_kind, " rd_data"}, rd_data, m_data);
    chk("R3 chan_on", chan_on, m_chon);
    chk("R8 unpk_on", unpk_on, m_unon);
    chk("R8 stream_open", stream_open, m_open);
  end

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic set_chan(input int ch, input logic [23:0] a, input int sz);
    wr(24'h004302 | (ch << 4), a[7:0]);
    wr(24'h004303 | (ch << 4), a[15:8]);
    wr(24'h004304 | (ch << 4), a[23:16]);
    wr(24'h004305 | (ch << 4), sz[7:0]);
    wr(24'h004306 | (ch << 4), sz[15:8]);
  endtask

  task automatic rd(input logic [23:0] a, input logic [7:0] rom, output logic [7:0] d);
    @(posedge clk); #1; rd_req = 1; rd_addr = a; rom_data = rom;
    @(posedge clk); #1; rd_req = 0;
    while (!rd_done) begin @(posedge clk); #1; end
    d = rd_data;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int base_done, base_init;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 chan_on", chan_on, 0);
    chk("R10 unpk_on", unpk_on, 0);
    chk("R10 stream_open", stream_open, 0);
    chk("R10 rd_done", rd_done, 0);
    chk("R10 unp_take", unp_take, 0);
    rst_n = 1;

    // R5 priority, R2 sizes, R8 completion, R7 with stalls
    fast = 0;
    set_chan(1, 24'hC12345, 3);
    set_chan(3, 24'hC12345, 2);
    wr(24'h004800, 8'h0A);
    wr(24'h004801, 8'h0A);
    rd(24'hC12345, 8'h99, d); chk("R6 first byte", d, 8'h45);
    rd(24'hC12345, 8'h99, d); chk("R7 second byte", d, 8'h44);
    rd(24'hC12345, 8'h99, d); chk("R7 third byte", d, 8'h47);
    chk("R5 ch1 disarmed first", unpk_on, 8'h08);
    chk("R8 stream closed", stream_open, 0);
    rd(24'hC12345, 8'h99, d); chk("R6 reinit byte", d, 8'h45);
    rd(24'hC12345, 8'h99, d); chk("R2 last of ch3", d, 8'h44);
    chk("R2 ch3 disarmed", unpk_on, 8'h00);
    fast = 1;

    // R4 ROM fall-through cases
    rd(24'hC12345, 8'h5A, d); chk("R4 disarmed match", d, 8'h5A);
    wr(24'h004801, 8'h0A);
    rd(24'h012345, 8'h3C, d); chk("R4 low bank", d, 8'h3C);
    rd(24'hC12346, 8'h3D, d); chk("R4 addr mismatch", d, 8'h3D);
    wr(24'h004801, 8'h00);

    // R1 mirror bank, ignored writes; R3 ignored enable writes
    wr(24'h804372, 8'hCD);
    wr(24'h804373, 8'hAB);
    wr(24'h804374, 8'hE0);
    wr(24'h804375, 8'h01);
    wr(24'h804376, 8'h00);
    wr(24'h404372, 8'h00);
    wr(24'h004382, 8'h00);
    wr(24'h404800, 8'hFF);
    wr(24'h004802, 8'hFF);
    chk("R3 ignored enable write", chan_on, 8'h0A);
    wr(24'h004800, 8'h80);
    wr(24'h004801, 8'h80);
    rd(24'hC0ABCD, 8'h11, d); chk("R1 bank byte kept", d, 8'h11);
    rd(24'hE0ABCD, 8'h11, d); chk("R1 shadow address", d, 8'hCD);
    chk("R1 size one done", unpk_on, 8'h00);

    // R9 zero size wraps
    set_chan(2, 24'hD00000, 0);
    wr(24'h004800, 8'h04);
    wr(24'h004801, 8'h04);
    rd(24'hD00000, 8'h00, d); chk("R9 first byte", d, 8'h00);
    chk("R9 still armed", unpk_on, 8'h04);
    wr(24'h004326, 8'h00);
    for (int i = 1; i <= 255; i++) begin
      rd(24'hD00000, 8'h00, d);
      if (i == 254) chk("R9 armed before end", unpk_on, 8'h04);
    end
    chk("R9 final byte", d, 8'hFF);
    chk("R9 disarmed", unpk_on, 8'h00);

    // R11 request during pending read
    fast = 0;
    set_chan(0, 24'hC00010, 2);
    wr(24'h004800, 8'h01);
    wr(24'h004801, 8'h01);
    base_done = n_done; base_init = n_init;
    @(posedge clk); #1; rd_req = 1; rd_addr = 24'hC00010; rom_data = 8'h66;
    @(posedge clk); #1; rd_addr = 24'h008000; rom_data = 8'h77;
    @(posedge clk); #1; rd_req = 0;
    while (!rd_done) begin @(posedge clk); #1; end
    chk("R11 stream byte", rd_data, 8'h10);
    repeat (8) @(posedge clk);
    #1;
    chk("R11 single done", n_done - base_done, 1);
    chk("R11 single init", n_init - base_init, 1);
    chk("R11 still armed", unpk_on, 8'h01);
    fast = 1;

    // R10 reset clears sizes and flags
    rst_n = 0;
    @(posedge clk); #1;
    chk("R10 unpk_on cleared", unpk_on, 0);
    chk("R10 open cleared", stream_open, 0);
    rst_n = 1;
    wr(24'h004302, 8'h10);
    wr(24'h004303, 8'h00);
    wr(24'h004304, 8'hC0);
    wr(24'h004800, 8'h01);
    wr(24'h004801, 8'h01);
    base_init = n_init;
    rd(24'hC00010, 8'h00, d); chk("R10 fresh stream", d, 8'h10);
    chk("R10 init after reset", n_init - base_init, 1);
    chk("R10 size was zero", unpk_on, 8'h01);

    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule